// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a two-wire serial slave that lets a host read and write a small bank of byte registers. The host's clock line and bidirectional data line are oversampled by the system clock. The block finds start and stop conditions, compares the 7-bit device address, acknowledges each byte it receives, and drives read data as an open-drain output enable. Raising the enable pulls the shared data line low. Lowering it releases the line to its pull-up.

The device address has two parts. The upper bits are a fixed prefix. The low bits come from address-select pins, so several copies of the block can share one bus. In a write transfer, the first byte after the address is a pointer byte. That pointer byte carries the register index and an auto-increment flag. A read transfer starts at the pointer as it was last left, so a host can write only the pointer byte, issue a repeated start, and read from that register.

There is no stream interface on this block. Both bus lines are asynchronous level inputs and the output enable is a plain level, so none of these ports uses valid/ready or back-pressure.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the output enable is low, the register pointer is 0, the auto-increment flag is clear and every register holds 0.
- R2: The block acknowledges only an address byte whose upper seven bits equal the prefix 00100 followed by addr_sel[1] and addr_sel[0]. For any other address it keeps SDA released, including on later bytes, until the next start condition.
- R3: Bit 0 of the address byte selects the direction: 0 means write and 1 means read.
- R4: In a write, the first byte after the address is the pointer byte. Bit 7 of that byte is the auto-increment flag and bits 2:0 are the register index. Each further byte in the same write is stored at the register the pointer selects.
- R5: When the flag is 1, the pointer advances by one after each stored byte and after each read byte the master acknowledges, and it wraps from 7 to 0. When the flag is 0, the pointer does not move.
- R6: A read drives the selected register MSB first, starting at the pointer as it was last left. The pointer and the flag are kept across stop and repeated-start conditions.
- R7: During the ninth clock of every byte it accepts (the matching address, the pointer byte and each data byte), the block holds SDA low.
- R8: After the master answers a read byte with a not-acknowledge, the block keeps SDA released until the next start condition.
- R9: A start condition (SDA falls while SCL is high) restarts address reception from any state. A partial data byte cut short this way is discarded. A stop condition (SDA rises while SCL is high) returns the block to idle with SDA released.
- R10: The output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Low bits of the device address |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (the resolved wired-AND) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases SDA |

## Verification
Writes are run with auto-increment on, with auto-increment off, and crossing the top register. Read-back then shows whether data went to consecutive registers, to one register, or wrapped to register 0. Reads are run with acknowledge-then-not-acknowledge sequences, so that pointer advance on an acknowledged byte can be told apart from the release that follows a not-acknowledge. A pointer-only write followed by a repeated start checks that the pointer persists, and a data byte cut off by a start checks that partial bytes never reach the bank. Mismatched prefixes, and a change on the select pins, tell address matching apart from a block that answers every address.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_MAP,
    ST_MACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // bus lines idle high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/i2c_rs_regbank.sv
module i2c_rs_regbank #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [IDXW-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && waddr == IDXW'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SELW = 2,
  parameter int IDXW = 3,
  parameter logic [DW-2-SELW:0] PREFIX = 5'b00100,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic [SELW-1:0] addr_sel,
  input  logic [DW-1:0]   rdata,
  output logic            sda_oe,
  output logic            we,
  output logic [IDXW-1:0] ptr,
  output logic [DW-1:0]   wdata
);
  slv_state_e    state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] rdsh;
  logic          rw;
  logic          inc;
  logic          byte_full;
  logic          addr_hit;

  assign byte_full = (bitcnt == CW'(DW));
  assign addr_hit  = (shreg[DW-1:1] == {PREFIX, addr_sel});
  assign we        = scl_fall && (state == ST_WDATA) && byte_full;
  assign wdata     = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      rdsh   <= '0;
      rw     <= 1'b0;
      inc    <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        ST_ADDR, ST_MAP, ST_WDATA: begin
          shreg  <= {shreg[DW-2:0], sda};
          bitcnt <= bitcnt + 1'b1;
        end
        ST_RACK: begin
          if (!sda) begin
            if (inc) ptr <= ptr + 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        ST_ADDR: begin
          if (byte_full) begin
            if (addr_hit) begin
              rw     <= shreg[0];
              sda_oe <= 1'b1;
              state  <= ST_AACK;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (rw) begin
            rdsh   <= rdata;
            sda_oe <= ~rdata[DW-1];
            bitcnt <= CW'(1);
            state  <= ST_RDATA;
          end else begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_MAP;
          end
        end
        ST_MAP: begin
          if (byte_full) begin
            ptr    <= shreg[IDXW-1:0];
            inc    <= shreg[DW-1];
            sda_oe <= 1'b1;
            state  <= ST_MACK;
          end
        end
        ST_MACK: begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          state  <= ST_WDATA;
        end
        ST_WDATA: begin
          if (byte_full) begin
            sda_oe <= 1'b1;
            state  <= ST_WACK;
          end
        end
        ST_WACK: begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          if (inc) ptr <= ptr + 1'b1;
          state  <= ST_WDATA;
        end
        ST_RDATA: begin
          if (byte_full) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            sda_oe <= ~rdsh[DW-2];
            rdsh   <= {rdsh[DW-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_RACK: begin
          rdsh   <= rdata;
          sda_oe <= ~rdata[DW-1];
          bitcnt <= CW'(1);
          state  <= ST_RDATA;
        end
        default: ;
      endcase
    end
  end

  // R10
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  // R10
  oe_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl || $past(start_ev || stop_ev)));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R7
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK || state == ST_MACK || state == ST_WACK) |-> sda_oe);

  // R8
  master_ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_oe);

  // R5
  ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise || scl_fall) |=> $stable(ptr));

  // R9
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CW'(DW));
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int NREG   = 8,
  parameter int DW     = 8,
  parameter int SELW   = 2,
  parameter int SYNC   = 2,
  parameter logic [DW-2-SELW:0] PREFIX = 5'b00100,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] addr_sel,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe
);
  logic            scl_s, scl_rise, scl_fall;
  logic            sda_s, sda_rise, sda_fall;
  logic            start_ev, stop_ev;
  logic            we;
  logic [IDXW-1:0] ptr;
  logic [DW-1:0]   wdata, rdata;

  i2c_rs_sync #(.STAGES(SYNC)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i),
    .q(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  i2c_rs_sync #(.STAGES(SYNC)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i),
    .q(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  // data edges while the clock is high are bus conditions, not data
  assign start_ev = sda_fall & scl_s;
  assign stop_ev  = sda_rise & scl_s;

  i2c_rs_fsm #(
    .DW(DW), .SELW(SELW), .IDXW(IDXW), .PREFIX(PREFIX)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .addr_sel(addr_sel), .rdata(rdata),
    .sda_oe(sda_oe), .we(we), .ptr(ptr), .wdata(wdata)
  );

  i2c_rs_regbank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(we), .waddr(ptr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata)
  );

  // R9
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
endmodule

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr_sel = 2'b01;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  wire        sda_line = m_sda & ~sda_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int r10_bad  = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  string      exp_tag [$];
  logic [7:0] exp_val [$];
  logic [7:0] got_q   [$];

  always #2.5 clk = ~clk;

  i2c_regslave u_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic [7:0] a, e;
      string t;
      wait (got_q.size() > 0);
      a = got_q.pop_front();
      e = exp_val.pop_front();
      t = exp_tag.pop_front();
      chk(t, a, e);
    end
  end

  // R10: enable must stay put while the clock line is high
  always @(posedge clk) begin
    if (rst_n && m_scl && sda_oe !== prev_oe) r10_bad++;
    prev_oe <= sda_oe;
  end

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  // driver: byte out, slave's ack bit checked through the scoreboard
  task automatic wb(input string tag, input logic [7:0] v, input logic exp_ack);
    logic a;
    exp_tag.push_back(tag);
    exp_val.push_back({7'b0, exp_ack});
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    got_q.push_back({7'b0, a});
  endtask

  // driver: byte in, then master answers with mack (0 = acknowledge)
  task automatic rb(input string tag, input logic [7:0] expv, input logic mack);
    logic [7:0] v;
    logic b;
    exp_tag.push_back(tag);
    exp_val.push_back(expv);
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(mack);
    got_q.push_back(v);
  endtask

  initial begin
    logic b;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1", {7'b0, sda_oe}, 8'h00);

    // R1 R3: read at pointer 0 after reset
    bus_start();
    wb("R3", 8'h23, 1'b0);
    rb("R1", 8'h00, 1'b1);
    bus_stop();

    // R2: wrong prefix is ignored, later bytes too
    bus_start();
    wb("R2", 8'h62, 1'b1);
    wb("R2", 8'h81, 1'b1);
    bus_stop();

    // R4 R7: incrementing write of three bytes to registers 2..4
    bus_start();
    wb("R7", 8'h22, 1'b0);
    wb("R4", 8'h82, 1'b0);
    wb("R7", 8'hA1, 1'b0);
    wb("R7", 8'hB2, 1'b0);
    wb("R7", 8'hC3, 1'b0);
    bus_stop();

    // R5: non-incrementing write leaves last byte in register 5
    bus_start();
    wb("R4", 8'h22, 1'b0);
    wb("R4", 8'h05, 1'b0);
    wb("R4", 8'h11, 1'b0);
    wb("R4", 8'h22, 1'b0);
    bus_stop();

    // R6 R5: pointer-only write, repeated start, burst read
    bus_start();
    wb("R6", 8'h22, 1'b0);
    wb("R6", 8'h82, 1'b0);
    bus_start();
    wb("R3", 8'h23, 1'b0);
    rb("R6", 8'hA1, 1'b0);
    rb("R5", 8'hB2, 1'b0);
    rb("R5", 8'hC3, 1'b1);
    // R8: released after not-acknowledge
    recv_bit(b);
    chk("R8", {7'b0, b}, 8'h01);
    recv_bit(b);
    chk("R8", {7'b0, b}, 8'h01);
    bus_stop();

    // R6: pointer persisted at 4 (not-acknowledged byte does not advance)
    bus_start();
    wb("R6", 8'h23, 1'b0);
    rb("R6", 8'hC3, 1'b1);
    bus_stop();

    // R5: no increment on read; register 6 untouched by the earlier write
    bus_start();
    wb("R5", 8'h22, 1'b0);
    wb("R5", 8'h05, 1'b0);
    bus_start();
    wb("R5", 8'h23, 1'b0);
    rb("R5", 8'h22, 1'b0);
    rb("R5", 8'h22, 1'b1);
    bus_stop();
    bus_start();
    wb("R5", 8'h22, 1'b0);
    wb("R5", 8'h06, 1'b0);
    bus_start();
    wb("R5", 8'h23, 1'b0);
    rb("R5", 8'h00, 1'b1);
    bus_stop();

    // R5: wrap from register 7 to 0
    bus_start();
    wb("R5", 8'h22, 1'b0);
    wb("R5", 8'h87, 1'b0);
    wb("R5", 8'h77, 1'b0);
    wb("R5", 8'h55, 1'b0);
    bus_stop();
    bus_start();
    wb("R5", 8'h22, 1'b0);
    wb("R5", 8'h87, 1'b0);
    bus_start();
    wb("R5", 8'h23, 1'b0);
    rb("R5", 8'h77, 1'b0);
    rb("R5", 8'h55, 1'b1);
    bus_stop();

    // R9: partial data byte cut by a start is discarded
    bus_start();
    wb("R9", 8'h22, 1'b0);
    wb("R9", 8'h01, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    wb("R9", 8'h23, 1'b0);
    rb("R9", 8'h00, 1'b1);
    bus_stop();
    tick(4);
    chk("R9", {7'b0, sda_oe}, 8'h00);

    // R2: select pins change the address
    addr_sel = 2'b10;
    tick(4);
    bus_start();
    wb("R2", 8'h22, 1'b1);
    bus_stop();
    bus_start();
    wb("R2", 8'h24, 1'b0);
    wb("R2", 8'h07, 1'b0);
    bus_start();
    wb("R2", 8'h25, 1'b0);
    rb("R2", 8'h77, 1'b1);
    bus_stop();

    wait (got_q.size() == 0);
    tick(4);
    chk("R10", r10_bad[7:0], 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule